// File: doc/BRIEF.md
# I2C Word-Oriented Control Slave

This block is the target end of a two-wire control port. An external host addresses it over an I2C bus and exchanges 32-bit control words with logic inside the chip. The bus lines are sampled into the system clock domain. Start, repeated start and stop are found by edge detection. The block answers only to its own 7-bit address. Written bytes are gathered four to a word, most significant byte first, and each finished word goes to the internal side on a valid/ready stream. Words that the internal side wants to send go into a small queue. The host reads them out one byte at a time, MSB byte first.

Two plain status pins tell the host how to pace itself. The active-low `irq_n` is low while outbound bytes are still waiting to be read. `stall` is high while a finished write word sits unaccepted in the block. If the host completes another word while `stall` is high, the block holds SCL low until the internal side accepts the waiting word. Both bus outputs are open-drain enables: 1 pulls the line low and 0 releases it.

Back-pressure rules on the streams work as follows. On the write stream, `wr_valid` stays high and `wr_data` stays stable until a cycle with `wr_ready` high. On the read stream, a word is queued in a cycle where `rd_valid` and `rd_ready` are both high, and `rd_ready` is low while the queue is full.

Top module: `i2c_word_slave`

## Requirements
- R1: After reset both bus enables are 0 (lines released), `irq_n` is 1, `stall` is 0, `wr_valid` is 0 and `rd_ready` is 1.
- R2: An address byte whose upper 7 bits equal `DEV_ADDR` (default 0x40) is ACKed with SDA low in the ninth clock. Any other address is not ACKed. After a non-matching address, the block drives nothing and ACKs nothing until the next start.
- R3: With bit 0 of the address byte at 0 (write), every data byte is ACKed. Four bytes form one word with the first byte in bits 31:24 and the fourth in bits 7:0. The word appears on `wr_data` with `wr_valid` and is held stable until `wr_ready`.
- R4: A stop that arrives with fewer than four bytes of a word received discards those bytes. The next written byte lands in bits 31:24.
- R5: A repeated start behaves exactly like a start. It discards a partial word and begins a new address phase, which may change direction.
- R6: With bit 0 of the address byte at 1 (read), the block sends queued words MSB byte first, MSB bit first. Bytes keep coming while the host ACKs. A host NACK ends the transfer.
- R7: `irq_n` is 0 while any queued or partly sent word has bytes left to send. It goes to 1 once the last pending byte has been taken for sending.
- R8: A read byte requested when nothing is pending is 0x00.
- R9: `stall` is 1 while a finished word waits on `wr_ready`. If a further word completes in that state, SCL is held low before the ACK of its last byte. The hold ends, and that byte is ACKed, once the waiting word is accepted.
- R10: The outbound queue holds `RD_DEPTH` words (default 4). `rd_ready` is 0 while it is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_oe | output | 1 | 1 pulls SDA low |
| wr_data | output | 32 | Word assembled from host writes |
| wr_valid | output | 1 | `wr_data` holds a word |
| wr_ready | input | 1 | Internal side accepts the word |
| rd_data | input | 32 | Word to queue for host reads |
| rd_valid | input | 1 | `rd_data` offered |
| rd_ready | output | 1 | Queue has room |
| irq_n | output | 1 | Low while outbound bytes are pending |
| stall | output | 1 | High while a written word awaits acceptance |

## Verification
The assertions assume a well-behaved bus master. It moves SDA only while SCL is low, except when it forms a start or a stop. It keeps each SCL phase longer than the synchronizer delay, and it never issues start or stop while the block is pulling a line low. The bench's master model changes SDA a full quarter bit period after its own SCL falls. It waits for SCL to actually rise before it times the high phase, so it respects a stretch. It sends stop only after the ACK or NACK bit has finished. Internal-side stimulus is driven on the falling clock edge and offers `rd_valid` only while `rd_ready` is high.

// File: rtl/i2c_word_pkg.sv
package i2c_word_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } eng_state_e;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_ff, sda_ff;
  logic              scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_out_queue.sv
module i2c_out_queue #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] push_data,
  input  logic         push_valid,
  output logic         push_ready,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         not_empty
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic [CW-1:0] count;
  logic          do_push;

  assign push_ready = (count != CW'(DEPTH));
  assign not_empty  = (count != '0);
  assign do_push    = push_valid & push_ready;
  assign head       = mem[rptr];

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= bump(wptr);
      if (pop)     rptr <= bump(rptr);
      case ({do_push, pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= push_data;
  end

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> not_empty); // R6

endmodule

// File: rtl/i2c_byte_feeder.sv
module i2c_byte_feeder #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] head,
  input  logic              not_empty,
  input  logic              load,
  output logic              pop,
  output logic [7:0]        byte_out,
  output logic              pending
);

  localparam int NB = WORD_W / 8;
  localparam int LW = $clog2(NB);
  localparam int RW = WORD_W - 8;

  logic [RW-1:0] rest;
  logic [LW-1:0] left;

  always_comb begin
    if (left != '0)     byte_out = rest[RW-1 -: 8];
    else if (not_empty) byte_out = head[WORD_W-1 -: 8];
    else                byte_out = 8'h00;
  end

  assign pop     = load & (left == '0) & not_empty;
  assign pending = (left != '0) | not_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rest <= '0;
      left <= '0;
    end else if (load) begin
      if (left != '0) begin
        rest <= rest << 8;
        left <= left - LW'(1);
      end else if (not_empty) begin
        rest <= head[RW-1:0];
        left <= LW'(NB - 1);
      end
    end
  end

  AST_IRQ_RISE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pending) |-> $past(load)); // R7

endmodule

// File: rtl/i2c_word_engine.sv
module i2c_word_engine
  import i2c_word_pkg::*;
#(
  parameter int         WORD_W   = 32,
  parameter logic [6:0] DEV_ADDR = 7'h40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [7:0]        rd_byte,
  output logic              rd_load,
  output logic [WORD_W-1:0] wr_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic              sda_oe,
  output logic              scl_oe
);

  localparam int NB = WORD_W / 8;
  localparam int BW = $clog2(NB);
  localparam int AW = WORD_W - 8;

  eng_state_e        state;
  logic [7:0]        sh, tx;
  logic [3:0]        bitcnt;
  logic              rw, m_ack;
  logic [BW-1:0]     byte_idx;
  logic [AW-1:0]     acc;
  logic [WORD_W-1:0] word_q;
  logic              wr_valid_q, sda_drv, scl_hold;
  logic              last_byte, slot_free;

  assign last_byte = (byte_idx == BW'(NB - 1));
  assign slot_free = ~wr_valid_q | wr_ready;
  assign rd_load   = scl_fall & (((state == ST_ADDR_ACK) & rw) |
                                 ((state == ST_RD_ACK) & m_ack));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      sh         <= '0;
      tx         <= '0;
      bitcnt     <= '0;
      rw         <= 1'b0;
      m_ack      <= 1'b0;
      byte_idx   <= '0;
      acc        <= '0;
      word_q     <= '0;
      wr_valid_q <= 1'b0;
      sda_drv    <= 1'b0;
      scl_hold   <= 1'b0;
    end else begin
      if (wr_valid_q && wr_ready) wr_valid_q <= 1'b0;

      if (start_det || stop_det) begin
        state    <= start_det ? ST_ADDR : ST_IDLE;
        bitcnt   <= '0;
        byte_idx <= '0;
        sda_drv  <= 1'b0;
        scl_hold <= 1'b0;
      end else begin
        unique case (state)
          ST_IDLE: ;
          ST_ADDR: begin
            if (scl_rise) begin
              sh     <= {sh[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              bitcnt <= '0;
              if (sh[7:1] == DEV_ADDR) begin
                rw      <= sh[0];
                sda_drv <= 1'b1;
                state   <= ST_ADDR_ACK;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              if (rw) begin
                tx      <= {rd_byte[6:0], 1'b0};
                sda_drv <= ~rd_byte[7];
                bitcnt  <= 4'd1;
                state   <= ST_RD;
              end else begin
                sda_drv <= 1'b0;
                bitcnt  <= '0;
                state   <= ST_WR;
              end
            end
          end
          ST_WR: begin
            if (scl_rise) begin
              sh     <= {sh[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              bitcnt <= '0;
              state  <= ST_WR_ACK;
              if (!last_byte) begin
                acc      <= (acc << 8) | AW'(sh);
                byte_idx <= byte_idx + BW'(1);
                sda_drv  <= 1'b1;
              end else if (slot_free) begin
                word_q     <= {acc, sh};
                wr_valid_q <= 1'b1;
                byte_idx   <= '0;
                sda_drv    <= 1'b1;
              end else begin
                scl_hold <= 1'b1;
              end
            end
          end
          ST_WR_ACK: begin
            if (scl_hold) begin
              if (slot_free) begin
                word_q     <= {acc, sh};
                wr_valid_q <= 1'b1;
                byte_idx   <= '0;
                sda_drv    <= 1'b1;
                scl_hold   <= 1'b0;
              end
            end else if (scl_fall) begin
              sda_drv <= 1'b0;
              state   <= ST_WR;
            end
          end
          ST_RD: begin
            if (scl_fall) begin
              if (bitcnt == 4'd8) begin
                sda_drv <= 1'b0;
                state   <= ST_RD_ACK;
              end else begin
                sda_drv <= ~tx[7];
                tx      <= tx << 1;
                bitcnt  <= bitcnt + 4'd1;
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) begin
              m_ack <= ~sda_s;
            end else if (scl_fall) begin
              if (m_ack) begin
                tx      <= {rd_byte[6:0], 1'b0};
                sda_drv <= ~rd_byte[7];
                bitcnt  <= 4'd1;
                state   <= ST_RD;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign wr_data  = word_q;
  assign wr_valid = wr_valid_q;
  assign sda_oe   = sda_drv;
  assign scl_oe   = scl_hold;

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data))); // R3

  AST_STRETCH_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_hold) |-> wr_valid_q); // R9

  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_drv) |-> !scl_s); // R2

endmodule

// File: rtl/i2c_word_slave.sv
module i2c_word_slave #(
  parameter int         WORD_W      = 32,
  parameter logic [6:0] DEV_ADDR    = 7'h40,
  parameter int         RD_DEPTH    = 4,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic [WORD_W-1:0] wr_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  input  logic [WORD_W-1:0] rd_data,
  input  logic              rd_valid,
  output logic              rd_ready,
  output logic              irq_n,
  output logic              stall
);

  logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              rd_load, pop, q_not_empty, pending;
  logic [WORD_W-1:0] q_head;
  logic [7:0]        tx_byte;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_out_queue #(.W(WORD_W), .DEPTH(RD_DEPTH)) u_queue (
    .clk(clk), .rst_n(rst_n), .push_data(rd_data), .push_valid(rd_valid),
    .push_ready(rd_ready), .pop(pop), .head(q_head), .not_empty(q_not_empty)
  );

  i2c_byte_feeder #(.WORD_W(WORD_W)) u_feeder (
    .clk(clk), .rst_n(rst_n), .head(q_head), .not_empty(q_not_empty),
    .load(rd_load), .pop(pop), .byte_out(tx_byte), .pending(pending)
  );

  i2c_word_engine #(.WORD_W(WORD_W), .DEV_ADDR(DEV_ADDR)) u_engine (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
    .stop_det(stop_det), .rd_byte(tx_byte), .rd_load(rd_load),
    .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .sda_oe(sda_oe), .scl_oe(scl_oe)
  );

  assign irq_n = ~pending;
  assign stall = wr_valid;

endmodule

// File: tb/i2c_word_slave_tb.sv
module i2c_word_slave_tb;

  localparam int Q = 10;
  localparam logic [6:0] ADDR = 7'h40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        m_scl_lo = 1'b0, m_sda_lo = 1'b0;
  logic        scl_line, sda_line;
  logic        scl_oe, sda_oe, wr_valid, wr_ready, rd_valid, rd_ready, irq_n, stall;
  logic [31:0] wr_data, rd_data;

  assign scl_line = ~(m_scl_lo | scl_oe);
  assign sda_line = ~(m_sda_lo | sda_oe);

  i2c_word_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .wr_data(wr_data), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .rd_data(rd_data), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .irq_n(irq_n), .stall(stall)
  );

  int nchk = 0, nfail = 0;
  logic [31:0] got_words [16];
  int got_n = 0;
  int stretch_cyc = 0;

  always @(posedge clk)
    if (rst_n && wr_valid && wr_ready && got_n < 16) begin
      got_words[got_n] <= wr_data;
      got_n <= got_n + 1;
    end

  always @(negedge clk) if (scl_oe) stretch_cyc <= stretch_cyc + 1;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic qwait();
    repeat (Q) @(negedge clk);
  endtask

  task automatic wait_scl_high();
    while (scl_line !== 1'b1) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda_lo = 1'b0; m_scl_lo = 1'b0; qwait();
    m_sda_lo = 1'b1; qwait();
    m_scl_lo = 1'b1; qwait();
  endtask

  task automatic bus_rstart();
    m_sda_lo = 1'b0; qwait();
    m_scl_lo = 1'b0; wait_scl_high(); qwait();
    m_sda_lo = 1'b1; qwait();
    m_scl_lo = 1'b1; qwait();
  endtask

  task automatic bus_stop();
    m_sda_lo = 1'b1; qwait();
    m_scl_lo = 1'b0; wait_scl_high(); qwait();
    m_sda_lo = 1'b0; qwait();
  endtask

  task automatic send_bit(input logic b);
    m_sda_lo = ~b; qwait();
    m_scl_lo = 1'b0; wait_scl_high(); qwait(); qwait();
    m_scl_lo = 1'b1; qwait();
  endtask

  task automatic recv_bit(output logic b);
    m_sda_lo = 1'b0; qwait();
    m_scl_lo = 1'b0; wait_scl_high(); qwait();
    b = sda_line; qwait();
    m_scl_lo = 1'b1; qwait();
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic nack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    recv_bit(nack);
  endtask

  task automatic rd_byte(input logic last, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) recv_bit(b[i]);
    send_bit(last);
  endtask

  task automatic push_word(input logic [31:0] w);
    @(negedge clk); rd_data = w; rd_valid = 1'b1;
    @(negedge clk); rd_valid = 1'b0;
  endtask

  task automatic send_word(input logic [31:0] w, input string req);
    logic a;
    for (int k = 3; k >= 0; k--) begin
      wr_byte(w[8*k +: 8], a);
      check(req, "data byte ACK", {31'd0, a}, 32'd0);
    end
  endtask

  task automatic t_reset();
    check("R1", "scl_oe", {31'd0, scl_oe}, 32'd0);
    check("R1", "sda_oe", {31'd0, sda_oe}, 32'd0);
    check("R1", "irq_n", {31'd0, irq_n}, 32'd1);
    check("R1", "stall", {31'd0, stall}, 32'd0);
    check("R1", "wr_valid", {31'd0, wr_valid}, 32'd0);
    check("R1", "rd_ready", {31'd0, rd_ready}, 32'd1);
  endtask

  task automatic t_write_word();
    logic a; int n0 = got_n;
    bus_start(); wr_byte({ADDR, 1'b0}, a);
    check("R2", "address ACK", {31'd0, a}, 32'd0);
    send_word(32'hDEADBEEF, "R3");
    bus_stop(); qwait();
    check("R3", "word count", got_n - n0, 1);
    check("R3", "word value", got_words[n0], 32'hDEADBEEF);
  endtask

  task automatic t_wrong_addr();
    logic a; int n0 = got_n;
    bus_start(); wr_byte({7'h41, 1'b0}, a);
    check("R2", "foreign address NACK", {31'd0, a}, 32'd1);
    wr_byte(8'h5A, a);
    check("R2", "byte after foreign address NACK", {31'd0, a}, 32'd1);
    bus_stop(); qwait();
    check("R2", "no word", got_n - n0, 0);
  endtask

  task automatic t_partial_discard();
    logic a; int n0 = got_n;
    bus_start(); wr_byte({ADDR, 1'b0}, a);
    wr_byte(8'h99, a); wr_byte(8'h88, a);
    bus_stop();
    bus_start(); wr_byte({ADDR, 1'b0}, a);
    send_word(32'h11223344, "R4");
    bus_stop(); qwait();
    check("R4", "word count", got_n - n0, 1);
    check("R4", "word after discard", got_words[n0], 32'h11223344);
  endtask

  task automatic t_rstart();
    logic a; logic [7:0] b; int n0 = got_n;
    bus_start(); wr_byte({ADDR, 1'b0}, a);
    wr_byte(8'hAA, a); wr_byte(8'hBB, a);
    bus_rstart(); wr_byte({ADDR, 1'b0}, a);
    check("R5", "address ACK after repeated start", {31'd0, a}, 32'd0);
    send_word(32'h01020304, "R5");
    bus_rstart(); wr_byte({ADDR, 1'b1}, a);
    check("R5", "read address ACK after repeated start", {31'd0, a}, 32'd0);
    rd_byte(1'b1, b);
    check("R8", "empty read byte", {24'd0, b}, 32'h0);
    bus_stop(); qwait();
    check("R5", "word count", got_n - n0, 1);
    check("R5", "word value", got_words[n0], 32'h01020304);
  endtask

  task automatic t_read_two();
    logic a; logic [7:0] b; logic [63:0] exp = 64'hA1B2C3D4_55667788;
    push_word(32'hA1B2C3D4); push_word(32'h55667788); qwait();
    check("R7", "irq_n low while pending", {31'd0, irq_n}, 32'd0);
    bus_start(); wr_byte({ADDR, 1'b1}, a);
    check("R6", "read address ACK", {31'd0, a}, 32'd0);
    for (int i = 0; i < 8; i++) begin
      rd_byte(i == 7, b);
      check("R6", $sformatf("read byte %0d", i), {24'd0, b}, {24'd0, exp[63-8*i -: 8]});
      if (i == 3) check("R7", "irq_n low after first word", {31'd0, irq_n}, 32'd0);
    end
    bus_stop(); qwait();
    check("R7", "irq_n high after last byte", {31'd0, irq_n}, 32'd1);
  endtask

  task automatic t_queue_full();
    logic a; logic [7:0] b;
    for (int w = 0; w < 4; w++) push_word(32'h10203040 + 32'h01010101 * w);
    @(negedge clk);
    check("R10", "rd_ready low when full", {31'd0, rd_ready}, 32'd0);
    bus_start(); wr_byte({ADDR, 1'b1}, a);
    for (int i = 0; i < 16; i++) begin
      logic [31:0] w = 32'h10203040 + 32'h01010101 * (i / 4);
      rd_byte(i == 15, b);
      check("R6", $sformatf("drain byte %0d", i), {24'd0, b}, {24'd0, w[31-8*(i%4) -: 8]});
    end
    bus_stop(); qwait();
    check("R10", "rd_ready after drain", {31'd0, rd_ready}, 32'd1);
    check("R7", "irq_n after drain", {31'd0, irq_n}, 32'd1);
    bus_start(); wr_byte({ADDR, 1'b1}, a); rd_byte(1'b1, b); bus_stop();
    check("R8", "read past end", {24'd0, b}, 32'h0);
  endtask

  task automatic t_stall();
    logic a; int n0 = got_n; int s0;
    wr_ready = 1'b0;
    bus_start(); wr_byte({ADDR, 1'b0}, a);
    send_word(32'hCAFEF00D, "R3");
    bus_stop(); repeat (20) @(negedge clk);
    check("R9", "stall high", {31'd0, stall}, 32'd1);
    check("R3", "wr_valid held", {31'd0, wr_valid}, 32'd1);
    check("R3", "wr_data held", wr_data, 32'hCAFEF00D);
    s0 = stretch_cyc;
    fork
      begin
        bus_start(); wr_byte({ADDR, 1'b0}, a);
        send_word(32'h0BADC0DE, "R9");
        bus_stop();
      end
      begin
        while (scl_oe !== 1'b1) @(negedge clk);
        repeat (100) @(negedge clk);
        check("R9", "SCL held low", {31'd0, scl_line}, 32'd0);
        wr_ready = 1'b1;
      end
    join
    qwait();
    check("R9", "stretch lasted", {31'd0, (stretch_cyc - s0) >= 100}, 32'd1);
    check("R9", "word count", got_n - n0, 2);
    check("R9", "first word", got_words[n0], 32'hCAFEF00D);
    check("R9", "second word", got_words[n0 + 1], 32'h0BADC0DE);
    check("R9", "stall low", {31'd0, stall}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    wr_ready = 1'b1; rd_valid = 1'b0; rd_data = '0;
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_write_word();
    t_wrong_addr();
    t_partial_discard();
    t_rstart();
    t_read_two();
    t_queue_full();
    t_stall();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule